// File: doc/BRIEF.md
# Mode-Selectable Inverting Bus Transceiver

This block is a bidirectional data path, nine bits wide by default, between a logic-side port and a wired-OR backplane port. The logic side is a tri-state port. It is modelled as a data vector plus one output-enable flag. The backplane side is open-collector. Each bit has a pull-down request, and the sampled line level comes back in on a separate input. A line that no bit pulls down reads high through the external pull-up.

Each direction has its own storage element. A two-bit mode code sets each element to one of three behaviours:
- pass-through;
- a latch that is open while its strobe is low;
- a register that loads on a rising strobe.

One code is asymmetric: it gives a register toward the backplane and a latch toward the logic side. Every path inverts its data.

The storage is emulated inside one system clock domain. A strobe is sampled on each clock edge. A register loads when its strobe is high at an edge and was low at the previous edge. A latch follows its input on every edge at which its strobe is low. While the strobe is high, the latch output shows the held value. A synchronous reset clears both elements and forces every backplane driver off. It stands in for the power-cycle guard on the backplane enable.

Top module: `xcvr9_top`

## Requirements
- R1: With `mode_sel` = 2'b00, both directions behave as latches.
- R2: With `mode_sel` = 2'b10, both directions are pass-through in the same cycle: `a_data` = ~`b_in`, and the forward output = ~`a_in`.
- R3: With `mode_sel` = 2'b01, both directions are registers. Each loads its input only at a clock edge where its own strobe (`fwd_strobe` toward B, `rev_strobe` toward A) is 1 and was 0 at the previous edge. Otherwise it keeps its value.
- R4: With `mode_sel` = 2'b11, the path toward B is a register and the path toward A is a latch.
- R5: A latch output equals the inverted live input while its strobe is 0. While the strobe is 1, the output equals the inverse of the input sampled at the last clock edge with the strobe at 0.
- R6: In every mode, the output of a direction is the bitwise inverse of the data its element passes or holds.
- R7: `a_oe` is 1 exactly when `a_oe_req` is 1.
- R8: The backplane drivers are enabled only when `b_en_hi` = 1, `b_en_lo_n` = 0 and reset is low. Otherwise `b_pull` is all zero, so every line reads as released (high).
- R9: With the drivers enabled, `b_pull[i]` = 1 exactly when forward output bit i is 0.
- R10: Each storage element keeps loading or holding as its mode and strobe dictate while the outputs of its direction are disabled.
- R11: While `rst` = 1 at a clock edge, both elements clear to zero, and `b_pull` stays all zero. After reset, a strobe that is already high is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Storage mode code |
| fwd_strobe | input | 1 | Load strobe of the path toward B |
| rev_strobe | input | 1 | Load strobe of the path toward A |
| a_in | input | W | Logic-side input data |
| a_data | output | W | Logic-side output data |
| a_oe_req | input | 1 | Logic-side output enable request |
| a_oe | output | 1 | Logic-side tri-state enable |
| b_in | input | W | Sampled backplane line levels |
| b_pull | output | W | Per-bit backplane pull-down request |
| b_en_hi | input | 1 | Backplane enable, active high |
| b_en_lo_n | input | 1 | Backplane enable, active low |

## Verification
The bench goes after these cases:
- A latch whose strobe rises while its data also changes. A design that closes the latch late would show the newer value.
- A register whose strobe stays high across several clocks. A level-sensitive design would keep reloading.
- A strobe that is already high when reset ends. A missing edge-detector rearm would capture a spurious word.
- The asymmetric mode code. A decoder error would make both directions the same kind.
- Every enable combination, and the reset cycles. A wrong enable gate would pull lines low while the port should be released.
- Loading while the outputs are disabled. A design that froze storage with the enables would show stale data once the port is enabled again.

// File: rtl/xcvr9_pkg.sv
package xcvr9_pkg;

  typedef enum logic [1:0] {
    ELEM_PASS  = 2'd0,
    ELEM_LATCH = 2'd1,
    ELEM_REG   = 2'd2
  } elem_kind_e;

  localparam logic [1:0] SEL_LATCH_BOTH = 2'b00;
  localparam logic [1:0] SEL_REG_BOTH   = 2'b01;
  localparam logic [1:0] SEL_PASS_BOTH  = 2'b10;
  localparam logic [1:0] SEL_SPLIT      = 2'b11;

  // element kind of the path toward the backplane
  function automatic elem_kind_e kind_fwd(input logic [1:0] sel);
    case (sel)
      SEL_PASS_BOTH: kind_fwd = ELEM_PASS;
      SEL_REG_BOTH:  kind_fwd = ELEM_REG;
      SEL_SPLIT:     kind_fwd = ELEM_REG;
      default:       kind_fwd = ELEM_LATCH;
    endcase
  endfunction

  // element kind of the path toward the logic side
  function automatic elem_kind_e kind_rev(input logic [1:0] sel);
    case (sel)
      SEL_PASS_BOTH: kind_rev = ELEM_PASS;
      SEL_REG_BOTH:  kind_rev = ELEM_REG;
      default:       kind_rev = ELEM_LATCH;
    endcase
  endfunction

  // backplane drivers active only for the one legal enable pair
  function automatic logic b_enable(input logic hi, input logic lo_n, input logic rst);
    b_enable = hi & ~lo_n & ~rst;
  endfunction

endpackage

// File: rtl/xcvr9_mode_dec.sv
module xcvr9_mode_dec
  import xcvr9_pkg::*;
(
  input  logic [1:0] mode_sel,
  output elem_kind_e fwd_kind,
  output elem_kind_e rev_kind
);

  always_comb begin
    fwd_kind = kind_fwd(mode_sel);
    rev_kind = kind_rev(mode_sel);
  end

endmodule

// File: rtl/xcvr9_stage.sv
module xcvr9_stage
  import xcvr9_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  elem_kind_e   kind,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] held,
  output logic         cap_evt,
  output logic         load_evt
);

  logic strobe_q;
  logic rise;

  assign rise     = strobe & ~strobe_q;
  assign cap_evt  = rise && (kind == ELEM_REG);
  assign load_evt = cap_evt || ((kind == ELEM_LATCH) && !strobe);

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '0;
      strobe_q <= 1'b1;   // a strobe high at reset exit is not an edge
    end else begin
      strobe_q <= strobe;
      if (load_evt) held <= din;
    end
  end

  always_comb begin
    case (kind)
      ELEM_PASS:  dout = ~din;
      ELEM_LATCH: dout = strobe ? ~held : ~din;
      default:    dout = ~held;
    endcase
  end

endmodule

// File: rtl/xcvr9_b_drv.sv
module xcvr9_b_drv #(
  parameter int W = 9
) (
  input  logic         drv_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] pull
);

  // open collector: a bit sinks current only for a driven zero
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pull[i] = drv_en & ~data[i];
  end

endmodule

// File: rtl/xcvr9_top.sv
module xcvr9_top
  import xcvr9_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_sel,
  input  logic         fwd_strobe,
  input  logic         rev_strobe,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_data,
  input  logic         a_oe_req,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_pull,
  input  logic         b_en_hi,
  input  logic         b_en_lo_n
);

  elem_kind_e   fwd_kind, rev_kind;
  logic [W-1:0] fwd_out, fwd_held, rev_held;
  logic         fwd_cap, rev_cap, fwd_load, rev_load;
  logic         b_drv_en;

  xcvr9_mode_dec u_dec (
    .mode_sel (mode_sel),
    .fwd_kind (fwd_kind),
    .rev_kind (rev_kind)
  );

  xcvr9_stage #(.W(W)) u_fwd (
    .clk      (clk),
    .rst      (rst),
    .kind     (fwd_kind),
    .strobe   (fwd_strobe),
    .din      (a_in),
    .dout     (fwd_out),
    .held     (fwd_held),
    .cap_evt  (fwd_cap),
    .load_evt (fwd_load)
  );

  xcvr9_stage #(.W(W)) u_rev (
    .clk      (clk),
    .rst      (rst),
    .kind     (rev_kind),
    .strobe   (rev_strobe),
    .din      (b_in),
    .dout     (a_data),
    .held     (rev_held),
    .cap_evt  (rev_cap),
    .load_evt (rev_load)
  );

  assign b_drv_en = b_enable(b_en_hi, b_en_lo_n, rst);
  assign a_oe     = a_oe_req;

  xcvr9_b_drv #(.W(W)) u_bdrv (
    .drv_en (b_drv_en),
    .data   (fwd_out),
    .pull   (b_pull)
  );

endmodule

// File: rtl/xcvr9_chk.sv
module xcvr9_chk
  import xcvr9_pkg::*;
#(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode_sel,
  input logic         rev_strobe,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_data,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_pull,
  input logic         b_en_hi,
  input logic         b_en_lo_n,
  input elem_kind_e   fwd_kind,
  input elem_kind_e   rev_kind,
  input logic [W-1:0] fwd_held,
  input logic [W-1:0] rev_held,
  input logic         fwd_cap
);

  assert_reset_release_R11: assert property (@(posedge clk)
    rst |-> (b_pull == '0));

  assert_pull_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (b_pull != '0) |-> (b_en_hi && !b_en_lo_n));

  assert_pass_rev_inverts_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10) |-> (a_data == ~b_in));

  assert_pass_fwd_pull_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10 && b_en_hi && !b_en_lo_n) |-> (b_pull == a_in));

  assert_reg_capture_R3: assert property (@(posedge clk) disable iff (rst)
    fwd_cap |=> (fwd_held == $past(a_in)));

  assert_reg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (fwd_kind == ELEM_REG && !fwd_cap) |=> $stable(fwd_held));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rev_kind == ELEM_LATCH && rev_strobe) |=> $stable(rev_held));

  assert_split_kinds_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |-> (fwd_kind == ELEM_REG && rev_kind == ELEM_LATCH));

endmodule

bind xcvr9_top xcvr9_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_sel   (mode_sel),
  .rev_strobe (rev_strobe),
  .a_in       (a_in),
  .a_data     (a_data),
  .b_in       (b_in),
  .b_pull     (b_pull),
  .b_en_hi    (b_en_hi),
  .b_en_lo_n  (b_en_lo_n),
  .fwd_kind   (fwd_kind),
  .rev_kind   (rev_kind),
  .fwd_held   (fwd_held),
  .rev_held   (rev_held),
  .fwd_cap    (fwd_cap)
);

// File: tb/xcvr9_top_test.sv
module xcvr9_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_sel = 2'b00;
  logic         fwd_strobe = 1'b0, rev_strobe = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         a_oe_req = 1'b0, b_en_hi = 1'b1, b_en_lo_n = 1'b0;
  logic [W-1:0] a_data, b_pull;
  logic         a_oe;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  logic [W-1:0] m_fwd, m_rev;
  bit m_fwd_prev, m_rev_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr9_top #(.W(W)) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .fwd_strobe(fwd_strobe), .rev_strobe(rev_strobe),
    .a_in(a_in), .a_data(a_data), .a_oe_req(a_oe_req), .a_oe(a_oe),
    .b_in(b_in), .b_pull(b_pull), .b_en_hi(b_en_hi), .b_en_lo_n(b_en_lo_n)
  );

  // 0 = pass, 1 = latch, 2 = register
  function automatic int kind_of(bit toward_b, logic [1:0] s);
    if (s == 2'b10) return 0;
    if (toward_b ? s[0] : (s == 2'b01)) return 2;
    return 1;
  endfunction

  function automatic logic [W-1:0] src_of(int k, bit strobe, logic [W-1:0] live, logic [W-1:0] kept);
    if (k == 0) return live;
    if (k == 1) return strobe ? kept : live;
    return kept;
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // called at a negedge after inputs are set; returns at the next negedge
  task automatic step(string tag);
    logic [W-1:0] e_fwd, e_pull;
    bit en;
    #(CLK_PERIOD/4);
    e_fwd  = ~src_of(kind_of(1, mode_sel), fwd_strobe, a_in, m_fwd);
    en     = b_en_hi && !b_en_lo_n && !rst;
    e_pull = en ? ~e_fwd : '0;
    check(tag, "b_pull", b_pull, e_pull);
    check(tag, "a_data", a_data, ~src_of(kind_of(0, mode_sel), rev_strobe, b_in, m_rev));
    check(tag, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, a_oe_req});
    @(posedge clk);
    if (rst) begin
      m_fwd = '0; m_rev = '0; m_fwd_prev = 1; m_rev_prev = 1;
    end else begin
      if ((kind_of(1, mode_sel) == 1 && !fwd_strobe) ||
          (kind_of(1, mode_sel) == 2 && fwd_strobe && !m_fwd_prev)) m_fwd = a_in;
      if ((kind_of(0, mode_sel) == 1 && !rev_strobe) ||
          (kind_of(0, mode_sel) == 2 && rev_strobe && !m_rev_prev)) m_rev = b_in;
      m_fwd_prev = fwd_strobe;
      m_rev_prev = rev_strobe;
    end
    @(negedge clk);
  endtask

  task automatic rnd_data();
    a_in = W'($urandom);
    b_in = W'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    m_fwd = '0; m_rev = '0; m_fwd_prev = 1; m_rev_prev = 1;
    @(negedge clk);

    // R11: reset with drivers requested on
    a_in = 9'h000; fwd_strobe = 1; mode_sel = 2'b01;
    repeat (2) step("R11");

    // R11: strobe already high at reset exit must not load
    rst = 0; a_in = 9'h0A5;
    repeat (2) step("R11");

    // R2: pass-through both ways
    mode_sel = 2'b10; a_oe_req = 1;
    for (int i = 0; i < 6; i++) begin rnd_data(); step("R2"); end

    // R1, R5: latches, open then closed with data changing
    mode_sel = 2'b00; fwd_strobe = 0; rev_strobe = 0;
    for (int i = 0; i < 3; i++) begin rnd_data(); step("R1"); end
    fwd_strobe = 1; rev_strobe = 1; rnd_data(); step("R5");
    for (int i = 0; i < 3; i++) begin rnd_data(); step("R5"); end
    fwd_strobe = 0; rev_strobe = 0; rnd_data(); step("R5");

    // R6: all-ones and all-zeros through the latch
    a_in = '1; b_in = '0; step("R6");
    a_in = '0; b_in = '1; step("R6");

    // R3: registers, strobe held high over several clocks
    mode_sel = 2'b01;
    for (int i = 0; i < 3; i++) begin rnd_data(); step("R3"); end
    fwd_strobe = 1; rev_strobe = 1; rnd_data(); step("R3");
    for (int i = 0; i < 4; i++) begin rnd_data(); step("R3"); end
    fwd_strobe = 0; rnd_data(); step("R3");
    fwd_strobe = 1; rev_strobe = 0; rnd_data(); step("R3");
    rev_strobe = 1; rnd_data(); step("R3");

    // R4: asymmetric code
    mode_sel = 2'b11; fwd_strobe = 0; rev_strobe = 0;
    for (int i = 0; i < 3; i++) begin rnd_data(); step("R4"); end
    fwd_strobe = 1; rev_strobe = 1; rnd_data(); step("R4");
    for (int i = 0; i < 3; i++) begin rnd_data(); step("R4"); end

    // R8, R9: every enable pair in pass-through
    mode_sel = 2'b10;
    for (int k = 0; k < 4; k++) begin
      b_en_hi = k[1]; b_en_lo_n = k[0];
      rnd_data(); step("R8");
      a_in = 9'h155; step("R9");
    end

    // R7: logic-side enable toggling
    a_oe_req = 0; rnd_data(); step("R7");
    a_oe_req = 1; rnd_data(); step("R7");

    // R10: load while both sides disabled, then enable and read back
    mode_sel = 2'b01; b_en_hi = 0; b_en_lo_n = 1; a_oe_req = 0;
    fwd_strobe = 0; rev_strobe = 0; step("R10");
    a_in = 9'h1C3; b_in = 9'h03C; fwd_strobe = 1; rev_strobe = 1; step("R10");
    rnd_data(); step("R10");
    b_en_hi = 1; b_en_lo_n = 0; a_oe_req = 1; step("R10");
    step("R10");

    // R11: reset in mid-run clears storage
    rst = 1; step("R11");
    rst = 0; rnd_data(); step("R11");
    step("R11");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule